// File: doc/BRIEF.md
# Dual-Side Integration Conversion Sequencer

This controller drives the conversion toggle of a current-integrating converter that has two integrator sides, A and B. While the conversion output is low, side A integrates. While it is high, side B integrates. Each toggle ends one side's integration and starts the other's. The integration period is counted in internal clock cycles from the `period` input. That input is sampled when the sequence starts and again at every toggle. A period below `MIN_CYC` or above `MAX_CYC` is refused.

After each normal toggle the block waits for the active-low data-valid input. When it sees data-valid low, it reports a one-cycle ready pulse tagged with the side that just stopped integrating. It also issues a single read-clock pulse so the converter can release data-valid. If data-valid does not arrive within twice the typical data-ready delay, a sticky timeout flag is raised.

A refused period sets a sticky error flag and starts a recovery sequence: three long integrations of `REC_CYC` cycles each, during which data-valid is ignored. Normal timing resumes at the end of the third one if the requested period is then acceptable. The `en` input starts the sequence, and dropping it returns the block to idle.

Top module: `conv_side_sequencer`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) `conv`, `rclk`, `rdy`, `rdy_side`, `err` and `tmo` are all 0 and the block is idle.
- R2: When `en` is first sampled high in idle with an acceptable period P, `conv` toggles exactly P clock edges later. Each later toggle comes P' edges after the previous one, where P' is the value of `period` sampled at that previous toggle edge.
- R3: `conv` low means side A integrates and high means side B integrates; `rdy_side` reports 0 for side A and 1 for side B. Consecutive ready events in normal operation carry alternating sides.
- R4: A toggle made in normal operation arms the data watch. The first edge at which `dvalid_n` is sampled low while armed produces `rdy` high for exactly the following cycle, with `rdy_side` equal to the `conv` level just before the arming toggle.
- R5: `rclk` goes high in the same cycle as `rdy` and low in the next cycle. `dvalid_n` low while the watch is not armed (idle, already served, or recovery) produces neither `rdy` nor `rclk`.
- R6: A period below `MIN_CYC` or above `MAX_CYC`, sampled at start or at a toggle, sets the sticky flag `err` and starts recovery. Recovery consists of three integrations of `REC_CYC` cycles each, with no `rdy` during them.
- R7: The toggle that ends the third recovery integration resumes normal operation with the sampled period and arms the data watch. If the period is still unacceptable, a fresh set of three recovery integrations begins.
- R8: If the watch stays armed for 2*`DR_TYP_CYC` edges without `dvalid_n` low, `tmo` is set (sticky until reset) and the watch is disarmed.
- R9: `en` sampled low forces idle: in the next cycle `conv`, `rclk` and `rdy` are 0 and the watch is cleared, while `err` and `tmo` keep their values.
- R10: While enabled, two consecutive `conv` toggles are never closer than `MIN_CYC` edges (`REC_CYC` is at least `MIN_CYC`).
- R11: A new toggle re-arms the watch and restarts the timeout count, so a period shorter than the timeout never raises `tmo` on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the sequence; low returns to idle |
| period | input | CW | Requested integration period in clock cycles |
| dvalid_n | input | 1 | Converter data-valid, active low |
| conv | output | 1 | Conversion toggle; low = side A integrating, high = side B |
| rclk | output | 1 | One-cycle read-clock pulse that releases data-valid |
| rdy | output | 1 | One-cycle data-ready event |
| rdy_side | output | 1 | Side whose data is ready (0 = A, 1 = B) |
| err | output | 1 | Sticky period-violation flag |
| tmo | output | 1 | Sticky data-ready timeout flag |

## Verification
Some properties are checked on every cycle by assertions: the read-clock pulse is one cycle wide and coincides with a ready event, every ready event follows a sampled low on data-valid, both flags are sticky, disabling clears the toggle, and a counter confirms that toggles never come closer than the minimum period. Other behaviours show only in the bench scenarios against its cycle model: exact period lengths, the side labels, the three-step recovery and its repetition while the period stays out of range, data-valid being ignored while it is stuck low through recovery, the timeout, and re-arming under short periods.

// File: rtl/conv_side_sequencer.sv
module conv_side_sequencer #(
  parameter int CW = 33,
  parameter logic [CW-1:0] MIN_CYC = CW'(1600),
  parameter logic [CW-1:0] MAX_CYC = CW'(64'd5000000000),
  parameter logic [CW-1:0] REC_CYC = CW'(5000),
  parameter int DR_TYP_CYC = 1382
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic          dvalid_n,
  output logic          conv,
  output logic          rclk,
  output logic          rdy,
  output logic          rdy_side,
  output logic          err,
  output logic          tmo
);
  localparam int TMO_CYC = 2 * DR_TYP_CYC;
  localparam int WW = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt, tgt;
  logic [1:0]    rcnt;
  logic          pend, pend_side;
  logic [WW-1:0] wcnt;

  wire ok     = (period >= MIN_CYC) && (period <= MAX_CYC);
  wire at_end = (cnt == tgt - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; tgt <= MIN_CYC; rcnt <= '0;
      pend <= 1'b0; pend_side <= 1'b0; wcnt <= '0;
      conv <= 1'b0; rclk <= 1'b0; rdy <= 1'b0; rdy_side <= 1'b0;
      err <= 1'b0; tmo <= 1'b0;
    end else if (!en) begin
      st <= S_IDLE; cnt <= '0; pend <= 1'b0;
      conv <= 1'b0; rclk <= 1'b0; rdy <= 1'b0;
    end else begin
      rclk <= 1'b0;
      rdy  <= 1'b0;
      if (pend) begin
        if (!dvalid_n) begin
          rdy <= 1'b1; rdy_side <= pend_side; rclk <= 1'b1; pend <= 1'b0;
        end else if (wcnt == WW'(TMO_CYC - 1)) begin
          tmo <= 1'b1; pend <= 1'b0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      case (st)
        S_IDLE: begin
          cnt <= '0; rcnt <= '0;
          if (ok) begin st <= S_RUN; tgt <= period; end
          else begin err <= 1'b1; st <= S_REC; tgt <= REC_CYC; end
        end
        default: begin
          if (at_end) begin
            cnt  <= '0;
            conv <= ~conv;
            if (st == S_REC && rcnt != 2'd2) begin
              rcnt <= rcnt + 1'b1;
            end else if (ok) begin
              st <= S_RUN; tgt <= period;
              pend <= 1'b1; pend_side <= conv; wcnt <= '0;
            end else begin
              err <= 1'b1; st <= S_REC; rcnt <= '0; tgt <= REC_CYC; pend <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  logic          conv_d, seen;
  logic [CW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      conv_d <= 1'b0; seen <= 1'b0; gap <= '0;
    end else begin
      conv_d <= conv;
      if (!en) seen <= 1'b0;
      else if (conv != conv_d) seen <= 1'b1;
      if (conv != conv_d) gap <= CW'(1);
      else if (gap != '1) gap <= gap + 1'b1;
    end
  end

  // R5
  rclk_one_cycle_chk: assert property (@(posedge clk) disable iff (rst) rclk |=> !rclk);
  // R5
  rclk_with_rdy_chk: assert property (@(posedge clk) disable iff (rst) rdy |-> rclk);
  // R4
  rdy_after_valid_chk: assert property (@(posedge clk) disable iff (rst) rdy |-> $past(!dvalid_n));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
  // R8
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (rst) tmo |=> tmo);
  // R9
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst) !en |=> (!conv && !rclk && !rdy));
  // R10
  min_spacing_chk: assert property (@(posedge clk) disable iff (rst) (seen && conv != conv_d) |-> gap >= MIN_CYC);
endmodule

// File: tb/conv_side_sequencer_tb.sv
module conv_side_sequencer_tb_top;
  localparam int MINC = 20, MAXC = 60, RECC = 50, DRT = 12, TMOC = 2 * DRT;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0;
  logic [15:0] period = 16'd30;
  logic conv, rclk, rdy, rdy_side, err, tmo;
  logic adc_low = 1'b0, spur = 1'b0;
  wire  dvalid_n = !(adc_low || spur);

  always #4 clk = ~clk;

  conv_side_sequencer #(.CW(16), .MIN_CYC(16'd20), .MAX_CYC(16'd60), .REC_CYC(16'd50), .DR_TYP_CYC(DRT)) dut_i (
    .clk(clk), .rst(rst), .en(en), .period(period), .dvalid_n(dvalid_n),
    .conv(conv), .rclk(rclk), .rdy(rdy), .rdy_side(rdy_side), .err(err), .tmo(tmo));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle model
  bit live = 1'b0;
  int m_mode = 0, m_left = 0, m_recs = 0, m_wait = 0;
  bit m_armed = 1'b0, m_aside = 1'b0;
  bit e_conv = 0, e_rclk = 0, e_rdy = 0, e_side = 0, e_err = 0, e_tmo = 0;
  int ecount = 0;

  always @(posedge clk) begin
    bit good, old;
    ecount++;
    live = 1'b1;
    good = (int'(period) >= MINC) && (int'(period) <= MAXC);
    if (rst) begin
      m_mode = 0; m_armed = 0; e_conv = 0; e_rclk = 0; e_rdy = 0;
      e_side = 0; e_err = 0; e_tmo = 0;
    end else if (!en) begin
      m_mode = 0; m_armed = 0; e_conv = 0; e_rclk = 0; e_rdy = 0;
    end else begin
      e_rclk = 0; e_rdy = 0;
      if (m_armed) begin
        if (!dvalid_n) begin e_rdy = 1; e_rclk = 1; e_side = m_aside; m_armed = 0; end
        else if (m_wait == TMOC - 1) begin e_tmo = 1; m_armed = 0; end
        else m_wait++;
      end
      if (m_mode == 0) begin
        m_recs = 0;
        if (good) begin m_mode = 1; m_left = int'(period); end
        else begin e_err = 1; m_mode = 2; m_left = RECC; end
      end else begin
        m_left--;
        if (m_left == 0) begin
          old = e_conv; e_conv = !e_conv;
          if (m_mode == 2 && m_recs < 2) begin m_recs++; m_left = RECC; end
          else if (good) begin
            m_mode = 1; m_left = int'(period); m_armed = 1; m_aside = old; m_wait = 0;
          end else begin
            e_err = 1; m_mode = 2; m_recs = 0; m_left = RECC;
          end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      chk(conv === e_conv, "R2 conv", int'(conv), int'(e_conv));
      chk(rdy === e_rdy, "R4 rdy", int'(rdy), int'(e_rdy));
      chk(rdy_side === e_side, "R3 rdy_side", int'(rdy_side), int'(e_side));
      chk(rclk === e_rclk, "R5 rclk", int'(rclk), int'(e_rclk));
      chk(err === e_err, "R6 err", int'(err), int'(e_err));
      chk(tmo === e_tmo, "R8 tmo", int'(tmo), int'(e_tmo));
    end
  end

  // converter model: data-valid low a set delay after each toggle, released by rclk fall
  int adc_dly = 5, adc_cnt = 0;
  bit adc_run = 0, adc_cv = 0, adc_rc = 0;
  always @(negedge clk) begin
    if (live) begin
      if (conv !== adc_cv) begin
        adc_cv = conv; adc_cnt = 0; adc_run = (adc_dly >= 0);
      end else if (adc_run) begin
        adc_cnt++;
        if (adc_cnt >= adc_dly) begin adc_low = 1'b1; adc_run = 0; end
      end
      if (adc_rc && !rclk) adc_low = 1'b0;
      adc_rc = rclk;
    end
  end

  // observation of toggles and ready events
  int last_tog = -1, last_gap = 0, min_gap = 1 << 30, first_tog = -1, start_edge = 0;
  int rdy_cnt = 0, rec_gaps = 0, tog_cnt = 0, alt_bad = 0;
  bit mon_cv = 0, have_side = 0, prev_side = 0;
  always @(negedge clk) begin
    if (live) begin
      if (conv !== mon_cv) begin
        mon_cv = conv;
        tog_cnt++;
        if (en && first_tog < 0) first_tog = ecount;
        if (last_tog >= 0 && en) begin
          last_gap = ecount - last_tog;
          if (last_gap < min_gap) min_gap = last_gap;
          if (last_gap == RECC) rec_gaps++;
        end
        last_tog = ecount;
      end
      if (rdy === 1'b1) begin
        rdy_cnt++;
        if (have_side && rdy_side == prev_side) alt_bad++;
        have_side = 1; prev_side = rdy_side;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    int c0;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    // R1 reset state
    chk(conv == 0 && rclk == 0 && rdy == 0 && rdy_side == 0, "R1 outputs after reset", int'({conv, rclk, rdy, rdy_side}), 0);
    chk(err == 0 && tmo == 0, "R1 flags after reset", int'({err, tmo}), 0);
    // R5 data-valid low while idle is ignored
    spur = 1'b1; cycles(4); spur = 1'b0; cycles(2);
    chk(rdy_cnt == 0 && rclk == 0, "R5 idle data-valid ignored", rdy_cnt, 0);
    // R2 start and first period
    period = 16'd30; en = 1'b1; start_edge = ecount + 1; first_tog = -1;
    cycles(200);
    chk(first_tog - start_edge == 30, "R2 first toggle distance", first_tog - start_edge, 30);
    chk(last_gap == 30, "R2 steady period", last_gap, 30);
    period = 16'd45; cycles(150);
    chk(last_gap == 45, "R2 period change applied", last_gap, 45);
    // R3 sides alternate
    chk(alt_bad == 0, "R3 side alternation", alt_bad, 0);
    chk(rdy_cnt >= 8, "R4 ready events seen", rdy_cnt, 8);
    // R11 short periods re-arm without timeout
    adc_dly = -1; period = 16'd20; cycles(120);
    chk(tmo == 0, "R11 no timeout with re-arm", int'(tmo), 0);
    chk(last_gap == 20, "R11 minimum period accepted", last_gap, 20);
    // R8 timeout
    period = 16'd30; cycles(100);
    chk(tmo == 1, "R8 timeout raised", int'(tmo), 1);
    adc_dly = 5; cycles(60);
    // R6 too-short period
    rec_gaps = 0;
    period = 16'd10; cycles(40);
    chk(err == 1, "R6 error flag", int'(err), 1);
    c0 = rdy_cnt;
    cycles(90);
    chk(rdy_cnt == c0, "R6 no ready during recovery", rdy_cnt - c0, 0);
    chk(rec_gaps >= 1, "R6 recovery integration length", rec_gaps, 1);
    // R7 resume after recovery
    period = 16'd30; cycles(120);
    chk(last_gap == 30, "R7 normal period after recovery", last_gap, 30);
    chk(rdy_cnt > c0, "R7 data capture resumed", rdy_cnt - c0, 1);
    // R7 repeated recovery while still out of range (above maximum)
    rec_gaps = 0;
    period = 16'd70; cycles(240);
    chk(rec_gaps >= 4, "R7 recovery repeats", rec_gaps, 4);
    period = 16'd30; cycles(200);
    chk(last_gap == 30, "R7 resume after repeated recovery", last_gap, 30);
    // R10
    chk(min_gap >= MINC, "R10 minimum toggle spacing", min_gap, MINC);
    // R9 disable
    en = 1'b0; cycles(2);
    chk(conv == 0 && rdy == 0 && rclk == 0, "R9 disabled outputs", int'({conv, rdy, rclk}), 0);
    chk(err == 1 && tmo == 1, "R9 flags kept", int'({err, tmo}), 3);
    c0 = tog_cnt; cycles(60);
    chk(tog_cnt == c0, "R9 no toggles while disabled", tog_cnt - c0, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      summary();
      $finish;
    end
  end
endmodule